// File: doc/BRIEF.md
# Network Controller Register Bank with Interrupt Control

This block is the 32-bit control and status register bank of a network controller. Software reaches it over a simple word-addressed register bus. Every stored word is built from a common cell that takes a per-bit read-only mask and a per-bit write-one-to-clear mask. On a write, the cell drops the protected bits of the incoming value. It keeps the old read-only and clear-on-one bits and then clears the clear-on-one bits that were written as one.

The bank holds a control word and a live status word. It also holds a transmit queue base and pointer, an interrupt status word, write-only enable and disable ports, and a read-only interrupt mask. The control word drives the loopback, receive-enable and transmit-enable outputs. A write to the control word can raise a one-cycle transmit start pulse and a one-cycle receive-descriptor fetch request. Event pulses from the receive and transmit engines latch into the interrupt status word only where their mask bits are clear. A registered level interrupt output reports any pending unmasked status bit.

The register map uses word addresses: 0 control, 1 status, 2 transmit queue base, 3 transmit queue pointer, 4 interrupt status, 5 interrupt enable, 6 interrupt disable, 7 interrupt mask. Control word fields: bit 1 loopback, bit 2 receive enable, bit 3 transmit enable, bit 9 transmit start. Bits 31 to 19 of the control word are read-only.

Top module: `netctl_regbank`

## Requirements
- R1: After reset the control word, the interrupt status word, the queue pointer, `rd_data_o` and `irq_o` are zero, and every implemented interrupt mask bit (low `N_IRQ` bits of address 7) is one.
- R2: Bits 31 to 19 of the control word (address 0) are read-only: written ones are discarded and those bits read back as zero. The other control bits, except bit 9, store the written value.
- R3: Write-one-to-clear bits clear only where a one is written and keep their value where a zero is written. Every bit of the interrupt status word (address 4) behaves this way, and so does control bit 9, which therefore always reads zero.
- R4: A write to address 6 ORs the written bits into the mask. A write to address 5 clears the written bits from the mask. Address 7 ignores writes, and addresses 5 and 6 read as zero.
- R5: An `irq_evt_i` bit sets its interrupt status bit at the next clock edge only when its mask bit is clear. An event wins over a clearing write to the same bit in the same cycle.
- R6: `irq_o` is a registered signal. It goes high in the cycle after the interrupt status word AND the inverted mask becomes nonzero, and it goes low in the cycle after that value becomes zero.
- R7: A write to address 0 with bit 9 set makes `tx_start_o` high for exactly the one cycle after the write edge. `loopback_o`, `rx_en_o` and `tx_en_o` follow stored control bits 1, 2 and 3.
- R8: A write to address 0 with bit 3 clear loads the transmit queue pointer (address 3, `txq_ptr_o`) from the base word at address 2. A write with bit 3 set leaves the pointer unchanged. A write to address 0 with bit 2 set makes `rx_fetch_o` high for the one cycle after the write edge.
- R9: Address 1 returns `net_status_i`, and writes to it have no effect.
- R10: Reads return data in `rd_data_o` one cycle after `rd_en_i`. Unmapped addresses (8 and above with the default width) read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 32 | Registered read data |
| irq_evt_i | input | N_IRQ | Event pulses from the receive and transmit engines |
| net_status_i | input | 32 | Live network status value |
| irq_o | output | 1 | Level interrupt |
| loopback_o | output | 1 | Local loopback enable |
| rx_en_o | output | 1 | Receive enable |
| tx_en_o | output | 1 | Transmit enable |
| tx_start_o | output | 1 | One-cycle transmit start pulse |
| rx_fetch_o | output | 1 | One-cycle receive descriptor fetch request |
| txq_ptr_o | output | 32 | Current transmit queue pointer |

## Verification
The bench builds the bank with `N_IRQ` = 12 and `ADDR_W` = 4. The narrow interrupt width shows that the mask resets to ones only in the implemented bits and that status reads are zero-extended. The 4-bit address leaves addresses 8 to 15 unmapped, so writes and reads there can be tested. With twelve events, one stimulus can carry masked and unmasked bits together. That pattern covers the race between an event and a clearing write to the same status bit, and the interrupt output falling after the disable port masks a bit that is still pending.

// File: rtl/netctl_pkg.sv
package netctl_pkg;
  localparam int DATA_W   = 32;

  localparam int A_CTRL   = 0;
  localparam int A_STAT   = 1;
  localparam int A_TXBASE = 2;
  localparam int A_TXPTR  = 3;
  localparam int A_ISR    = 4;
  localparam int A_IEN    = 5;
  localparam int A_IDIS   = 6;
  localparam int A_IMASK  = 7;

  localparam int CB_LOOP  = 1;
  localparam int CB_RXEN  = 2;
  localparam int CB_TXEN  = 3;
  localparam int CB_TXGO  = 9;

  localparam logic [DATA_W-1:0] CTRL_RO_MASK  = 32'hFFF8_0000;
  localparam logic [DATA_W-1:0] CTRL_W1C_MASK = 32'h0000_0200;
endpackage

// File: rtl/nc_mask_reg.sv
module nc_mask_reg #(
  parameter int             W        = 32,
  parameter logic [W-1:0]   RO_MASK  = '0,
  parameter logic [W-1:0]   W1C_MASK = '0,
  parameter logic [W-1:0]   RST_VAL  = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] KEEP_MASK = RO_MASK | W1C_MASK;

  logic [W-1:0] q_q, wr_val, wr_next, d;

  always_comb begin
    wr_val  = wdata_i & ~RO_MASK;
    wr_next = (wr_val & ~W1C_MASK) | (q_q & KEEP_MASK);
    wr_next = wr_next & ~(W1C_MASK & wr_val);
    d       = (we_i ? wr_next : q_q) | set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q_q <= RST_VAL;
    else         q_q <= d;

  assign q_o = q_q;

  assert_ro_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && set_i == '0) |=> ((q_o & RO_MASK) == $past(q_o & RO_MASK)));

  assert_w1c_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && |(wdata_i & W1C_MASK & ~set_i))
      |=> ((q_o & $past(wdata_i & W1C_MASK & ~set_i)) == '0));

  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_i && set_i == '0) |=> $stable(q_o));
endmodule

// File: rtl/nc_irq_ctrl.sv
module nc_irq_ctrl #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         isr_we_i,
  input  logic         ien_we_i,
  input  logic         idis_we_i,
  input  logic [N-1:0] wdata_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] isr_o,
  output logic [N-1:0] imask_o,
  output logic         irq_o
);
  logic [N-1:0] imask_q, evt_set;
  logic         irq_q;

  assign evt_set = evt_i & ~imask_q;

  nc_mask_reg #(
    .W(N), .RO_MASK('0), .W1C_MASK({N{1'b1}}), .RST_VAL('0)
  ) u_isr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(isr_we_i),
    .wdata_i(wdata_i), .set_i(evt_set), .q_o(isr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)        imask_q <= {N{1'b1}};
    else if (idis_we_i) imask_q <= imask_q | wdata_i;
    else if (ien_we_i)  imask_q <= imask_q & ~wdata_i;

  // level output re-evaluated one cycle after status or mask moves
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(isr_o & ~imask_q);

  assign imask_o = imask_q;
  assign irq_o   = irq_q;

  assert_idis_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idis_we_i |=> ((imask_o & $past(wdata_i)) == $past(wdata_i)));

  assert_ien_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_we_i && !idis_we_i) |=> ((imask_o & $past(wdata_i)) == '0));

  assert_masked_evt_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(evt_i & imask_o & ~isr_o) |=> ((isr_o & $past(evt_i & imask_o & ~isr_o)) == '0));

  assert_evt_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(evt_i & ~imask_o) |=> ((isr_o & $past(evt_i & ~imask_o)) == $past(evt_i & ~imask_o)));

  assert_irq_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|(isr_o & ~imask_o)));

  assert_irq_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> !$past(|(isr_o & ~imask_o)));
endmodule

// File: rtl/netctl_regbank.sv
module netctl_regbank
  import netctl_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int N_IRQ  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [31:0]       rd_data_o,
  input  logic [N_IRQ-1:0]  irq_evt_i,
  input  logic [31:0]       net_status_i,
  output logic              irq_o,
  output logic              loopback_o,
  output logic              rx_en_o,
  output logic              tx_en_o,
  output logic              tx_start_o,
  output logic              rx_fetch_o,
  output logic [31:0]       txq_ptr_o
);
  localparam int PAD_W = DATA_W - N_IRQ;

  logic wr_ctrl, wr_base, wr_isr, wr_ien, wr_idis;
  logic [DATA_W-1:0] ctrl_q, base_q, ptr_q, rd_mux, rd_q;
  logic [N_IRQ-1:0]  isr, imask;
  logic              txgo_q, rxfetch_q;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_base = wr_en_i && (addr_i == ADDR_W'(A_TXBASE));
  assign wr_isr  = wr_en_i && (addr_i == ADDR_W'(A_ISR));
  assign wr_ien  = wr_en_i && (addr_i == ADDR_W'(A_IEN));
  assign wr_idis = wr_en_i && (addr_i == ADDR_W'(A_IDIS));

  nc_mask_reg #(
    .W(DATA_W), .RO_MASK(CTRL_RO_MASK), .W1C_MASK(CTRL_W1C_MASK), .RST_VAL('0)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_ctrl),
    .wdata_i(wdata_i), .set_i('0), .q_o(ctrl_q)
  );

  nc_mask_reg #(
    .W(DATA_W), .RO_MASK('0), .W1C_MASK('0), .RST_VAL('0)
  ) u_txbase (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(wr_base),
    .wdata_i(wdata_i), .set_i('0), .q_o(base_q)
  );

  nc_irq_ctrl #(.N(N_IRQ)) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .isr_we_i(wr_isr), .ien_we_i(wr_ien), .idis_we_i(wr_idis),
    .wdata_i(wdata_i[N_IRQ-1:0]), .evt_i(irq_evt_i),
    .isr_o(isr), .imask_o(imask), .irq_o(irq_o)
  );

  // queue pointer reloads whenever transmit enable is written low
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                           ptr_q <= '0;
    else if (wr_ctrl && !wdata_i[CB_TXEN]) ptr_q <= base_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      txgo_q    <= 1'b0;
      rxfetch_q <= 1'b0;
    end else begin
      txgo_q    <= wr_ctrl && wdata_i[CB_TXGO];
      rxfetch_q <= wr_ctrl && wdata_i[CB_RXEN];
    end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(A_CTRL):   rd_mux = ctrl_q;
      ADDR_W'(A_STAT):   rd_mux = net_status_i;
      ADDR_W'(A_TXBASE): rd_mux = base_q;
      ADDR_W'(A_TXPTR):  rd_mux = ptr_q;
      ADDR_W'(A_ISR):    rd_mux = {{PAD_W{1'b0}}, isr};
      ADDR_W'(A_IMASK):  rd_mux = {{PAD_W{1'b0}}, imask};
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)      rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;

  assign rd_data_o  = rd_q;
  assign loopback_o = ctrl_q[CB_LOOP];
  assign rx_en_o    = ctrl_q[CB_RXEN];
  assign tx_en_o    = ctrl_q[CB_TXEN];
  assign tx_start_o = txgo_q;
  assign rx_fetch_o = rxfetch_q;
  assign txq_ptr_o  = ptr_q;

  assert_txgo_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_start_o |-> $past(wr_en_i && addr_i == ADDR_W'(A_CTRL) && wdata_i[CB_TXGO]));

  assert_txgo_never_stored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q[CB_TXGO]);

  assert_ptr_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == ADDR_W'(A_CTRL)) |=> $stable(txq_ptr_o));

  assert_unmapped_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i > ADDR_W'(A_IMASK)) |=> ($stable(ctrl_q) && $stable(base_q)));
endmodule

// File: tb/netctl_regbank_test.sv
module netctl_regbank_test;
  localparam int ADDR_W = 4;
  localparam int N_IRQ  = 12;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0]       rd_data;
  logic [N_IRQ-1:0]  evt = '0;
  logic [31:0]       nstat = '0;
  logic irq, loopb, rxen, txen, txgo, rxfetch;
  logic [31:0]       txptr;

  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_pend = 1'b0;

  always #4 clk = ~clk;

  netctl_regbank #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .irq_evt_i(evt), .net_status_i(nstat), .irq_o(irq),
    .loopback_o(loopb), .rx_en_o(rxen), .tx_en_o(txen),
    .tx_start_o(txgo), .rx_fetch_o(rxfetch), .txq_ptr_o(txptr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  always @(posedge clk) mon_pend <= rd_en;
  always @(negedge clk)
    if (mon_pend && exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());

  task automatic wr(input int a, input logic [31:0] d);
    addr = ADDR_W'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] exp, input string tag);
    addr = ADDR_W'(a); rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [N_IRQ-1:0] v);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog (all): actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_o", {31'b0, irq}, 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);
    rd(0, 32'h0, "R1 ctrl");
    rd(4, 32'h0, "R1 isr");
    rd(7, 32'h0000_0FFF, "R1 mask");
    rd(3, 32'h0, "R1 ptr");

    // R2/R3/R7/R8 control word
    wr(0, 32'hFFFF_FFFF);
    chk("R7 tx_start pulse", {31'b0, txgo}, 32'h1);
    chk("R8 rx_fetch pulse", {31'b0, rxfetch}, 32'h1);
    @(negedge clk);
    chk("R7 tx_start one cycle", {31'b0, txgo}, 32'h0);
    chk("R8 rx_fetch one cycle", {31'b0, rxfetch}, 32'h0);
    chk("R7 ctrl outputs", {29'b0, txen, rxen, loopb}, 32'h7);
    rd(0, 32'h0007_FDFF, "R2 R3 ctrl ro and txgo bits");

    wr(2, 32'h1000_0040);
    rd(3, 32'h0, "R8 ptr kept with tx enable set");
    wr(0, 32'h0000_0002);
    chk("R7 loop only", {29'b0, txen, rxen, loopb}, 32'h1);
    chk("R8 txq_ptr_o", txptr, 32'h1000_0040);
    rd(3, 32'h1000_0040, "R8 ptr reload");

    // R9 status
    nstat = 32'hA5A5_0F0F;
    wr(1, 32'h0);
    rd(1, 32'hA5A5_0F0F, "R9 live status");

    // R10 unmapped
    wr(9, 32'hDEAD_BEEF);
    rd(9, 32'h0, "R10 unmapped read");
    rd(0, 32'h0000_0002, "R10 ctrl untouched");
    rd(2, 32'h1000_0040, "R10 base untouched");

    // R5 masked events
    pulse_evt(12'h005);
    rd(4, 32'h0, "R5 masked events ignored");

    // R4 mask ports
    wr(5, 32'h0000_0003);
    rd(7, 32'h0000_0FFC, "R4 enable clears");
    wr(7, 32'h0);
    rd(7, 32'h0000_0FFC, "R4 mask write ignored");
    wr(6, 32'h0000_0002);
    rd(7, 32'h0000_0FFE, "R4 disable sets");
    rd(6, 32'h0, "R4 disable reads zero");
    wr(5, 32'h0000_0003);

    // R5/R6 unmasked events
    pulse_evt(12'h007);
    chk("R6 irq not yet", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R6 irq rises", {31'b0, irq}, 32'h1);
    rd(4, 32'h0000_0003, "R5 only unmasked latch");

    // R3 write one to clear
    wr(4, 32'h0000_0001);
    rd(4, 32'h0000_0002, "R3 isr w1c partial");
    chk("R6 irq stays", {31'b0, irq}, 32'h1);
    wr(4, 32'h0000_0002);
    chk("R6 irq lags clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R6 irq falls", {31'b0, irq}, 32'h0);

    // R5 event beats same-cycle clear
    pulse_evt(12'h001);
    addr = ADDR_W'(4); wdata = 32'h1; wr_en = 1'b1; evt = 12'h001;
    @(negedge clk);
    wr_en = 1'b0; evt = '0;
    rd(4, 32'h0000_0001, "R5 event wins over clear");
    chk("R6 irq pending", {31'b0, irq}, 32'h1);

    // R6 disable masks a pending bit
    wr(6, 32'h0000_0001);
    chk("R6 irq lags mask", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R6 irq masked", {31'b0, irq}, 32'h0);
    rd(4, 32'h0000_0001, "R6 status kept while masked");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule